// File: doc/BRIEF.md
# Serial Receive DMA Engine with Chained Buffer Sets

This block moves bytes from one serial receiver into memory without processor help. It holds two buffer descriptors, an active set and a standby set. Each set is a start address and a byte count. Every received byte is written to the active address. The active address then steps up by one and the active count steps down by one. When the active count runs out, the standby set is copied into the active set in the same cycle and an interrupt pulse is raised. Reception then carries on into the new buffer without losing a byte.

The standby set is not cleared by that copy. If software points the standby set at the start of the active buffer, the engine runs a circular receive buffer for as long as it is enabled. Software tracks progress by reading the live active address and comparing it with its own read pointer. It can also chain separate buffers by writing a fresh standby set after each interrupt. When both counts are exhausted, incoming bytes are discarded and a sticky overrun flag is set.

The control path has two states. ST_IDLE waits for a byte and moves to ST_WRITE when one is captured. ST_WRITE holds the memory request until it is accepted, then returns to ST_IDLE.

Top module: `serial_rx_dma`

## Requirements
- R1: After reset all five registers read zero, the engine is disabled, and neither `mem_valid` nor `irq` is asserted.
- R2: The register select values are 0 for the active address, 1 for the active count, 2 for the standby address, 3 for the standby count, and 4 for control. Control bit 0 is the enable and reads back as written. Control bit 1 reads as the overrun flag. Address and count fields read back as written, truncated to their widths and zero-extended.
- R3: With the engine enabled and the active count non-zero, a byte on `rx_valid`/`rx_data` is written to memory at the active address. Once the write is accepted, the active address increases by one, wrapping at its width, and the active count decreases by one. The path is ST_IDLE to ST_WRITE to ST_IDLE.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_data` stay stable. The active registers change only by a software write.
- R5: When an accepted write takes the active count from 1 to 0, the active set is loaded from the standby set on that edge and `irq` is high during the accepting cycle. The standby set keeps its value, and the next byte goes to the new buffer.
- R6: With the standby set equal to the initial active set (base B, length L), byte k is written to address B + (k mod L), and one reload occurs for every L bytes.
- R7: A byte that arrives while enabled, in ST_IDLE, with both counts zero, is not written and sets the overrun flag. The flag stays set until a control write with bit 1 equal to 1 clears it. A control write with bit 1 equal to 0 leaves the flag as it is.
- R8: A byte that arrives while a write is pending in ST_WRITE, including the accepting cycle, is not written and sets the overrun flag.
- R9: While the engine is disabled, incoming bytes cause no memory write, no overrun and no register change.
- R10: A byte that arrives in ST_IDLE with the active count zero and the standby count non-zero causes an immediate reload and an `irq` pulse, and the byte is written to the standby address. The active set then reads standby address + 1 and standby count - 1.
- R11: A software write to the active set while a write is pending does not redirect the pending byte. After acceptance, the active set holds the software values, with no increment and no reload.
- R12: A software write to the standby set in the same cycle as a reload loads the old standby values into the active set, while the standby set takes the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte strobe from the serial receiver |
| rx_data | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` (combinational) |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_data | output | 8 | Memory write data |
| irq | output | 1 | Pulse when the active set is reloaded from the standby set |

## Verification
The delicate coincidence is a buffer reload on an accepted memory write in the same cycle as a software write. The bench provokes it by stalling `mem_ready`, so that a write is pending with an active count of one. It then raises `mem_ready` and writes the standby address in the same cycle, and checks that the active set took the old standby values while the standby register holds the new one. A second collision writes the active address during a stall. The bench judges it by the address of the stalled byte and by the active set after acceptance.

// File: rtl/srxdma_pkg.sv
package srxdma_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } dma_state_e;

    localparam logic [2:0] SEL_CUR_ADDR = 3'd0;
    localparam logic [2:0] SEL_CUR_CNT  = 3'd1;
    localparam logic [2:0] SEL_NXT_ADDR = 3'd2;
    localparam logic [2:0] SEL_NXT_CNT  = 3'd3;
    localparam logic [2:0] SEL_CTRL     = 3'd4;
endpackage

// File: rtl/srxdma_regs.sv
module srxdma_regs
    import srxdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              adv,
    input  logic              reload,
    input  logic              drop_set,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [CNT_W-1:0]  nxt_cnt,
    output logic              enable,
    output logic              overrun,
    output logic              cur_wr
);
    logic wr_ca, wr_cc, wr_na, wr_nc, wr_ctl;
    logic unused_wdata;

    assign wr_ca  = reg_wr && (reg_sel == SEL_CUR_ADDR);
    assign wr_cc  = reg_wr && (reg_sel == SEL_CUR_CNT);
    assign wr_na  = reg_wr && (reg_sel == SEL_NXT_ADDR);
    assign wr_nc  = reg_wr && (reg_sel == SEL_NXT_CNT);
    assign wr_ctl = reg_wr && (reg_sel == SEL_CTRL);
    assign cur_wr = wr_ca || wr_cc;
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
            nxt_addr <= '0;
            nxt_cnt  <= '0;
            enable   <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (wr_ca)       cur_addr <= reg_wdata[ADDR_W-1:0];
            else if (reload) cur_addr <= nxt_addr;
            else if (adv)    cur_addr <= cur_addr + 1'b1;

            if (wr_cc)       cur_cnt <= reg_wdata[CNT_W-1:0];
            else if (reload) cur_cnt <= nxt_cnt;
            else if (adv)    cur_cnt <= cur_cnt - 1'b1;

            if (wr_na) nxt_addr <= reg_wdata[ADDR_W-1:0];
            if (wr_nc) nxt_cnt  <= reg_wdata[CNT_W-1:0];
            if (wr_ctl) enable  <= reg_wdata[0];

            if (drop_set)                    overrun <= 1'b1;
            else if (wr_ctl && reg_wdata[1]) overrun <= 1'b0;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_CUR_ADDR: reg_rdata = 32'(cur_addr);
            SEL_CUR_CNT:  reg_rdata = 32'(cur_cnt);
            SEL_NXT_ADDR: reg_rdata = 32'(nxt_addr);
            SEL_NXT_CNT:  reg_rdata = 32'(nxt_cnt);
            SEL_CTRL:     reg_rdata = {30'd0, overrun, enable};
            default:      reg_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/srxdma_fsm.sv
module srxdma_fsm
    import srxdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [CNT_W-1:0]  nxt_cnt,
    input  logic              cur_wr,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              adv,
    output logic              reload,
    output logic              drop_set,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    dma_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              hold_q;
    logic              cur_empty, nxt_empty;
    logic              start, idle_rl, accept, keep, end_rl;

    assign cur_empty = (cur_cnt == '0);
    assign nxt_empty = (nxt_cnt == '0);
    assign start   = (state == ST_IDLE) && enable && rx_valid && !(cur_empty && nxt_empty);
    assign idle_rl = start && cur_empty && !cur_wr;
    assign accept  = (state == ST_WRITE) && mem_ready;
    assign keep    = hold_q || cur_wr;
    assign end_rl  = accept && !keep && (cur_cnt == CNT_ONE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)  state_nx = ST_WRITE;
            ST_WRITE: if (accept) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        mem_valid = (state == ST_WRITE);
        mem_addr  = addr_q;
        mem_data  = data_q;
        reload    = idle_rl || end_rl;
        adv       = accept && !keep && !end_rl;
        irq       = reload;
        drop_set  = enable && rx_valid &&
                    ((state == ST_WRITE) || (cur_empty && nxt_empty));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            hold_q <= 1'b0;
        end else begin
            if (start) begin
                addr_q <= idle_rl ? nxt_addr : cur_addr;
                data_q <= rx_data;
                hold_q <= cur_wr;
            end else if (accept) begin
                hold_q <= 1'b0;
            end else if (state == ST_WRITE && cur_wr) begin
                hold_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_rx_dma.sv
module serial_rx_dma #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_data,
    output logic              irq
);
    logic [ADDR_W-1:0] cur_addr, nxt_addr;
    logic [CNT_W-1:0]  cur_cnt, nxt_cnt;
    logic              enable, overrun, cur_wr;
    logic              adv, reload, drop_set;

    srxdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .adv(adv), .reload(reload), .drop_set(drop_set),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt), .nxt_addr(nxt_addr), .nxt_cnt(nxt_cnt),
        .enable(enable), .overrun(overrun), .cur_wr(cur_wr)
    );

    srxdma_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt), .nxt_addr(nxt_addr), .nxt_cnt(nxt_cnt),
        .cur_wr(cur_wr), .mem_ready(mem_ready),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .adv(adv), .reload(reload), .drop_set(drop_set), .irq(irq)
    );
endmodule

// File: rtl/srxdma_chk.sv
module srxdma_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              reg_wr,
    input logic [2:0]        reg_sel,
    input logic [31:0]       reg_wdata,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_data,
    input logic              irq,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [ADDR_W-1:0] nxt_addr,
    input logic [CNT_W-1:0]  nxt_cnt,
    input logic              enable,
    input logic              overrun
);
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    p_cur_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready && !reg_wr |=> $stable(cur_addr) && $stable(cur_cnt));

    p_reload_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready && irq && !reg_wr
        |=> cur_addr == $past(nxt_addr) && cur_cnt == $past(nxt_cnt));

    p_exhausted_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid && enable && rx_valid && cur_cnt == '0 && nxt_cnt == '0
        |=> !mem_valid && overrun);

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !(reg_wr && reg_sel == 3'd4 && reg_wdata[1]) |=> overrun);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid && !enable |=> !mem_valid);
endmodule

bind serial_rx_dma srxdma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .irq(irq), .cur_addr(cur_addr), .cur_cnt(cur_cnt), .nxt_addr(nxt_addr),
    .nxt_cnt(nxt_cnt), .enable(enable), .overrun(overrun)
);

// File: tb/tb_serial_rx_dma.sv
module tb_serial_rx_dma;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_valid;
    logic          mem_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;
    logic          irq;

    int tests = 0;
    int fails = 0;
    int nlog = 0;
    int nirq = 0;
    logic [AW-1:0] log_addr [256];
    logic [7:0]    log_data [256];

    serial_rx_dma #(.ADDR_W(AW), .CNT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            log_addr[nlog % 256] = mem_addr;
            log_data[nlog % 256] = mem_data;
            nlog++;
        end
        if (irq) nirq++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int start, sirq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), v);
            check("R1 reg reset", v, 32'd0);
        end
        check("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R2 register readback with truncation
        wr(3'd0, 32'hABCD_1234); rd(3'd0, v); check("R2 cur addr", v, 32'h1234);
        wr(3'd1, 32'h0000_01F7); rd(3'd1, v); check("R2 cur cnt", v, 32'hF7);
        wr(3'd2, 32'h0000_5678); rd(3'd2, v); check("R2 nxt addr", v, 32'h5678);
        wr(3'd3, 32'h0000_0033); rd(3'd3, v); check("R2 nxt cnt", v, 32'h33);
        wr(3'd4, 32'h0000_0001); rd(3'd4, v); check("R2 ctrl", v, 32'h1);
        wr(3'd4, 32'h0000_0000);

        // R3 R5 R6 ring sweep over lengths and bases
        for (int b = 0; b < 2; b++) begin
            for (int len = 1; len <= 4; len++) begin
                int base, n;
                base = (b == 0) ? 32'h0100 : 32'hFFFE;
                n = 3 * len + 1;
                wr(3'd4, 32'h0);
                wr(3'd0, base); wr(3'd1, len);
                wr(3'd2, base); wr(3'd3, len);
                wr(3'd4, 32'h3);
                start = nlog; sirq = nirq;
                for (int k = 0; k < n; k++) begin
                    send(8'(k ^ 8'h5A));
                    check("R3 R6 ring addr", 32'(log_addr[(start + k) % 256]),
                          32'((base + (k % len)) & 16'hFFFF));
                    check("R3 data", 32'(log_data[(start + k) % 256]), 32'(8'(k ^ 8'h5A)));
                end
                check("R5 reload count", nirq - sirq, 32'(n / len));
                rd(3'd0, v); check("R3 cur addr after", v, 32'((base + (n % len)) & 16'hFFFF));
                rd(3'd1, v); check("R3 cur cnt after", v, 32'(len - (n % len)));
                rd(3'd3, v); check("R5 nxt cnt kept", v, 32'(len));
            end
        end

        // R5 chain then R7 exhaustion
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h200); wr(3'd1, 2); wr(3'd2, 32'h300); wr(3'd3, 3);
        wr(3'd4, 32'h3);
        start = nlog; sirq = nirq;
        send(8'h11); send(8'h22);
        check("R5 irq after first buffer", nirq - sirq, 1);
        rd(3'd0, v); check("R5 cur addr reloaded", v, 32'h300);
        rd(3'd1, v); check("R5 cur cnt reloaded", v, 3);
        wr(3'd2, 32'h0); wr(3'd3, 32'h0);
        send(8'h33); send(8'h44); send(8'h55);
        check("R5 chain addr", 32'(log_addr[(start + 4) % 256]), 32'h302);
        check("R5 irq after second buffer", nirq - sirq, 2);
        send(8'h66);
        check("R7 dropped byte", nlog - start, 5);
        rd(3'd4, v); check("R7 overrun set", v, 32'h3);
        wr(3'd4, 32'h1); rd(3'd4, v); check("R7 overrun kept", v, 32'h3);
        wr(3'd4, 32'h3); rd(3'd4, v); check("R7 overrun cleared", v, 32'h1);

        // R10 idle reload on arrival
        wr(3'd2, 32'h400); wr(3'd3, 2);
        start = nlog; sirq = nirq;
        send(8'h77);
        check("R10 irq", nirq - sirq, 1);
        check("R10 addr", 32'(log_addr[start % 256]), 32'h400);
        rd(3'd0, v); check("R10 cur addr", v, 32'h401);
        rd(3'd1, v); check("R10 cur cnt", v, 1);

        // R9 disabled
        wr(3'd4, 32'h0);
        start = nlog;
        send(8'h88);
        check("R9 no write", nlog - start, 0);
        rd(3'd4, v); check("R9 no overrun", v, 0);
        rd(3'd0, v); check("R9 cur unchanged", v, 32'h401);

        // R4 R8 R11 stall
        wr(3'd0, 32'h500); wr(3'd1, 4); wr(3'd2, 32'h500); wr(3'd3, 4);
        wr(3'd4, 32'h3);
        start = nlog;
        mem_ready = 1'b0;
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'hA1;
        @(negedge clk); rx_valid = 1'b0;
        check("R4 valid held", {31'd0, mem_valid}, 1);
        check("R4 addr", 32'(mem_addr), 32'h500);
        rx_valid = 1'b1; rx_data = 8'hB2;
        @(negedge clk); rx_valid = 1'b0;
        rd(3'd4, v); check("R8 overrun on busy", v, 32'h3);
        rd(3'd0, v); check("R4 cur frozen", v, 32'h500);
        wr(3'd0, 32'h600);
        check("R11 pending addr unchanged", 32'(mem_addr), 32'h500);
        mem_ready = 1'b1;
        @(negedge clk);
        check("R11 pending byte addr", 32'(log_addr[start % 256]), 32'h500);
        check("R11 pending byte data", 32'(log_data[start % 256]), 32'hA1);
        rd(3'd0, v); check("R11 cur addr kept", v, 32'h600);
        rd(3'd1, v); check("R11 cur cnt kept", v, 4);
        check("R8 only one write", nlog - start, 1);
        send(8'hC3);
        check("R11 next byte addr", 32'(log_addr[(start + 1) % 256]), 32'h600);
        rd(3'd0, v); check("R11 cur advanced", v, 32'h601);

        // R12 reload coinciding with standby write
        wr(3'd0, 32'h700); wr(3'd1, 1); wr(3'd2, 32'h800); wr(3'd3, 5);
        sirq = nirq;
        mem_ready = 1'b0;
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'hD4;
        @(negedge clk); rx_valid = 1'b0;
        reg_wr = 1'b1; reg_sel = 3'd2; reg_wdata = 32'h900; mem_ready = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        rd(3'd0, v); check("R12 cur addr old standby", v, 32'h800);
        rd(3'd1, v); check("R12 cur cnt old standby", v, 5);
        rd(3'd2, v); check("R12 standby new", v, 32'h900);
        check("R12 irq", nirq - sirq, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule